// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits between a processor's instruction fetch port and a memory read master. Every fetch byte address is cut into three fields. The low five bits are the offset within a 32-byte line. The next bits select one of the cache lines, and the remaining upper bits form the tag. A fetch whose line is valid and whose tag matches completes in the same cycle it is presented. The block returns the 32-bit instruction word from its local storage.

On a miss the block starts a refill of the whole line, which is eight 32-bit words. It issues one read request per clock. The first request is for the word the processor asked for, and the rest follow in ascending order, wrapping modulo eight. The stalled fetch completes in the cycle that first word comes back, and the word is forwarded directly from the memory data input. While the remaining words stream in, a fetch to the same line completes as soon as its word has arrived. A fetch to any other line waits until the refill is over.

A line-invalidate command clears the valid bit of the line its address selects. This command also serves as the flush operation. If the invalidated line is the one being refilled, that line stays invalid when the refill ends. The number of lines and the address width are parameters.

Top module: `icache_direct`

## Requirements
- R1: A fetch byte address splits into offset bits [4:0], word select bits [4:2], line index bits [4+log2(LINES):5] and tag (all higher bits). Bits [1:0] do not affect which word is returned.
- R2: A fetch whose line is valid with a matching tag, presented while no refill runs, asserts fetch_done in the same cycle with the stored word.
- R3: A miss produces exactly eight read requests on consecutive clocks, with no gap, starting the cycle after the miss is seen.
- R4: The first request address is the missed word's address. Each later request keeps the line bits [ADDR_W-1:5] and advances bits [4:2] by one modulo 8.
- R5: A missed fetch completes in the cycle its word returns on mem_rvalid and carries mem_rdata. With memory latency L this is L+2 cycles after the fetch was first presented, counting the presentation cycle as the first.
- R6: During a refill, a fetch to the line being filled completes once its word has arrived, or in the same cycle it arrives, before the refill ends.
- R7: During a refill, a fetch to any other line does not complete until all eight words of the refill have been received.
- R8: An invalidate command clears the valid bit of the line selected by inval_addr, so the next fetch to that line misses.
- R9: An invalidate of the line under refill leaves that line invalid after the refill completes.
- R10: Reset clears all valid bits, so the first fetch to any line after reset misses. Out of reset, fetch_done and mem_req are low.
- R11: Direct mapping: a refill of a line with a new tag replaces the previous contents, so a fetch with the old tag misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch request, held until fetch_done |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_done | output | 1 | Fetch completes this cycle |
| fetch_word | output | 32 | Instruction word, valid with fetch_done |
| inval_valid | input | 1 | Invalidate/flush command for one line |
| inval_addr | input | ADDR_W | Byte address selecting the line to invalidate |
| mem_req | output | 1 | Read request, one word per clock |
| mem_addr | output | ADDR_W | Word-aligned byte address of the read |
| mem_rvalid | input | 1 | Read data returned, in request order |
| mem_rdata | input | 32 | Returned read data |

## Verification
The bench builds the cache with four lines and a 16-bit address, and it models memory with a two-cycle read latency. With only four lines, random addresses drawn from a few tags collide on the same line index often, so evictions and invalidations are frequent. The two-cycle latency leaves a window in which a fetch can be issued mid-refill, both to the line being filled and to other lines. This exposes critical-word forwarding, service from beats already received, and the kill of a line invalidated during its own refill.

// File: rtl/icache_pkg.sv
// Shared constants and types for the instruction cache.
// Assumes 32-bit words and 32-byte lines (eight words per line).
package icache_pkg;
    localparam int OFS_W   = 5;
    localparam int SEL_W   = 3;
    localparam int BEATS   = 8;
    localparam int WORD_W  = 32;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/icache_tags.sv
// Tag and valid storage with hit compare for a direct-mapped cache.
// Assumes LINES is a power of two. Only valid bits are reset.
module icache_tags #(
    parameter int LINES = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             fill_start,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_end,
    input  logic             fill_keep,
    input  logic             inval,
    input  logic [IDX_W-1:0] inval_idx
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Hit when the selected line is valid and holds the same tag.
    assign hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

    // Valid bits: cleared at fill start, set at fill end, cleared by invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (fill_start)            valid_q[fill_idx]  <= 1'b0;
            if (fill_end && fill_keep) valid_q[fill_idx]  <= 1'b1;
            if (inval)                 valid_q[inval_idx] <= 1'b0;
        end
    end

    // Tag store: written once when a refill begins.
    always_ff @(posedge clk) begin
        if (fill_start) tag_q[fill_idx] <= fill_tag;
    end
endmodule

// File: rtl/icache_data.sv
// Instruction word storage, LINES x 8 words, asynchronous read.
// Assumes one write per clock from the refill stream.
module icache_data
    import icache_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  sel_t             wr_sel,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  sel_t             rd_sel,
    output word_t            rd_data
);
    localparam int DEPTH = LINES * BEATS;

    word_t mem_q [DEPTH];

    // Combinational read of the addressed word.
    assign rd_data = mem_q[{rd_idx, rd_sel}];

    // Refill write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{wr_idx, wr_sel}] <= wr_data;
    end
endmodule

// File: rtl/icache_refill.sv
// Refill sequencer: issues eight reads critical word first, counts the
// returned beats and tracks which words of the line have arrived.
// Assumes memory returns exactly the requested words, in request order,
// at least one cycle after each request.
module icache_refill
    import icache_pkg::*;
#(
    parameter int ADDR_W = 31,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [IDX_W-1:0]  start_idx,
    input  sel_t              start_sel,
    input  logic              inval,
    input  logic [IDX_W-1:0]  inval_idx,
    input  logic              mem_rvalid,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [TAG_W-1:0]  line_tag,
    output logic [IDX_W-1:0]  line_idx,
    output logic [BEATS-1:0]  have,
    output sel_t              wr_sel,
    output logic              fill_end,
    output logic              fill_keep
);
    fill_state_e      state_q;
    logic [TAG_W-1:0] tag_q;
    logic [IDX_W-1:0] idx_q;
    sel_t             crit_q;
    logic [SEL_W:0]   req_cnt_q;
    sel_t             rsp_cnt_q;
    logic [BEATS-1:0] have_q;
    logic             kill_q;
    logic             inval_here;

    assign busy       = (state_q == ST_FILL);
    assign mem_req    = busy && !req_cnt_q[SEL_W];
    assign mem_addr   = {tag_q, idx_q, sel_t'(crit_q + req_cnt_q[SEL_W-1:0]), 2'b00};
    assign wr_sel     = sel_t'(crit_q + rsp_cnt_q);
    assign fill_end   = busy && mem_rvalid && (rsp_cnt_q == sel_t'(BEATS - 1));
    assign inval_here = inval && (inval_idx == idx_q);
    assign fill_keep  = !kill_q && !inval_here;
    assign line_tag   = tag_q;
    assign line_idx   = idx_q;
    assign have       = have_q;

    // Sequencer state, counters, arrived-beat mask and kill flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tag_q     <= '0;
            idx_q     <= '0;
            crit_q    <= '0;
            req_cnt_q <= '0;
            rsp_cnt_q <= '0;
            have_q    <= '0;
            kill_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q   <= ST_FILL;
                        tag_q     <= start_tag;
                        idx_q     <= start_idx;
                        crit_q    <= start_sel;
                        req_cnt_q <= '0;
                        rsp_cnt_q <= '0;
                        have_q    <= '0;
                        kill_q    <= inval && (inval_idx == start_idx);
                    end
                end
                ST_FILL: begin
                    if (mem_req) req_cnt_q <= req_cnt_q + 1'b1;
                    if (mem_rvalid) begin
                        rsp_cnt_q      <= rsp_cnt_q + 1'b1;
                        have_q[wr_sel] <= 1'b1;
                    end
                    if (inval_here) kill_q  <= 1'b1;
                    if (fill_end)   state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/icache_direct.sv
// Direct-mapped instruction cache top. Single-cycle hits, critical-word-first
// refill with forwarding, per-line invalidate.
// Assumes the fetch port holds fetch_valid/fetch_addr until fetch_done and
// that memory accepts one read per clock and answers in order.
module icache_direct
    import icache_pkg::*;
#(
    parameter int ADDR_W = 31,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_done,
    output logic [31:0]       fetch_word,
    input  logic              inval_valid,
    input  logic [ADDR_W-1:0] inval_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    logic [TAG_W-1:0] f_tag;
    logic [IDX_W-1:0] f_idx;
    sel_t             f_sel;
    logic [IDX_W-1:0] i_idx;
    logic             hit;
    logic             busy;
    logic             start;
    logic [TAG_W-1:0] line_tag;
    logic [IDX_W-1:0] line_idx;
    logic [BEATS-1:0] have;
    sel_t             wr_sel;
    logic             fill_end;
    logic             fill_keep;
    word_t            rd_data;
    logic             same_line;
    logic             beat_now;
    logic             unused_bits;

    // Address field split.
    assign f_tag = fetch_addr[ADDR_W-1 -: TAG_W];
    assign f_idx = fetch_addr[OFS_W +: IDX_W];
    assign f_sel = fetch_addr[OFS_W-1:2];
    assign i_idx = inval_addr[OFS_W +: IDX_W];
    assign unused_bits = ^{fetch_addr[1:0], inval_addr[ADDR_W-1 -: TAG_W], inval_addr[OFS_W-1:0]};

    assign start = fetch_valid && !busy && !hit;

    icache_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(f_idx), .rd_tag(f_tag), .hit(hit),
        .fill_start(start), .fill_idx(busy ? line_idx : f_idx), .fill_tag(f_tag),
        .fill_end(fill_end), .fill_keep(fill_keep),
        .inval(inval_valid), .inval_idx(i_idx)
    );

    icache_refill #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_refill (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_tag(f_tag), .start_idx(f_idx), .start_sel(f_sel),
        .inval(inval_valid), .inval_idx(i_idx),
        .mem_rvalid(mem_rvalid),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .line_tag(line_tag), .line_idx(line_idx), .have(have),
        .wr_sel(wr_sel), .fill_end(fill_end), .fill_keep(fill_keep)
    );

    icache_data #(.LINES(LINES), .IDX_W(IDX_W)) u_data (
        .clk(clk),
        .wr_en(busy && mem_rvalid), .wr_idx(line_idx), .wr_sel(wr_sel), .wr_data(mem_rdata),
        .rd_idx(f_idx), .rd_sel(f_sel), .rd_data(rd_data)
    );

    // Fetch completion: hit when idle; during refill only for arrived or arriving words.
    assign same_line = (f_tag == line_tag) && (f_idx == line_idx);
    assign beat_now  = mem_rvalid && (wr_sel == f_sel);

    always_comb begin
        if (busy) begin
            fetch_done = fetch_valid && same_line && (have[f_sel] || beat_now);
            fetch_word = (beat_now && !have[f_sel]) ? mem_rdata : rd_data;
        end else begin
            fetch_done = fetch_valid && hit;
            fetch_word = rd_data;
        end
    end
endmodule

// File: rtl/icache_chk.sv
// Protocol checks on the refill request stream and the fetch handshake.
// Assumes memory latency of at least one cycle.
module icache_chk #(
    parameter int ADDR_W = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              fetch_done,
    input logic              mem_req,
    input logic [ADDR_W-3:0] mem_waddr
);
    logic [2:0] cnt_q;

    // Position of the next request within the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (mem_req) cnt_q <= cnt_q + 1'b1;
    end

    // R3
    req_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (cnt_q != 3'd7) |=> mem_req);

    // R3
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (cnt_q == 3'd7) |=> !mem_req);

    // R4
    wrap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (cnt_q != 3'd0) |-> mem_waddr[2:0] == 3'($past(mem_waddr[2:0]) + 3'd1));

    // R4
    line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (cnt_q != 3'd0) |-> $stable(mem_waddr[ADDR_W-3:3]));

    // R2
    done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> fetch_valid);
endmodule

bind icache_direct icache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_done(fetch_done),
    .mem_req(mem_req), .mem_waddr(mem_addr[ADDR_W-1:2])
);

// File: tb/sim_icache_direct.sv
module sim_icache_direct;
    localparam int AW  = 16;
    localparam int NL  = 4;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fetch_done;
    logic [31:0]   fetch_word;
    logic          inval_valid = 1'b0;
    logic [AW-1:0] inval_addr = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [31:0]   mem_rdata;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    icache_direct #(.ADDR_W(AW), .LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_done(fetch_done), .fetch_word(fetch_word),
        .inval_valid(inval_valid), .inval_addr(inval_addr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        return {a[AW-1:2], 2'b00} * 32'h9E37_79B1 ^ 32'h5A3C_0F1E;
    endfunction

    // Memory model with fixed read latency.
    logic          v1 = 1'b0, v2 = 1'b0;
    logic [AW-1:0] a1 = '0, a2 = '0;
    always @(posedge clk) begin
        v1 <= mem_req; a1 <= mem_addr;
        v2 <= v1;      a2 <= a1;
    end
    assign mem_rvalid = v2;
    assign mem_rdata  = mem_word(a2);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Request stream monitor with bench-side expected burst order.
    int            req_total = 0, rsp_total = 0;
    logic [2:0]    req_pos = 3'd0;
    logic [AW-6:0] pend_line = '0, cur_line = '0;
    logic [2:0]    pend_first = '0, cur_first = '0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_rvalid) rsp_total <= rsp_total + 1;
            if (mem_req) begin
                req_total <= req_total + 1;
                req_pos   <= req_pos + 3'd1;
                if (req_pos == 3'd0) begin
                    // R4 first request is the missed word
                    chk(mem_addr == {pend_line, pend_first, 2'b00}, "R4 first word",
                        32'(mem_addr), 32'({pend_line, pend_first, 2'b00}));
                    cur_line  <= pend_line;
                    cur_first <= pend_first;
                end else begin
                    // R4 wrap-around order
                    chk(mem_addr == {cur_line, 3'(cur_first + req_pos), 2'b00}, "R4 order",
                        32'(mem_addr), 32'({cur_line, 3'(cur_first + req_pos), 2'b00}));
                end
            end else if (req_pos != 3'd0) begin
                // R3 requests on consecutive clocks
                chk(1'b0, "R3 gap in burst", 32'(req_pos), 32'd0);
            end
        end
    end

    // Reference tag/valid model.
    bit        vm [NL];
    int        tm [NL];
    int        last_k;
    int        last_rsp;
    int        last_req;

    task automatic do_fetch(input logic [AW-1:0] addr, input bit lat_chk, input string req);
        int idx = int'(addr[6:5]);
        int tg  = int'(addr[AW-1:7]);
        bit mh  = vm[idx] && (tm[idx] == tg);
        int k   = 0;
        if (!mh) begin
            pend_line  = addr[AW-1:5];
            pend_first = addr[4:2];
        end
        fetch_valid = 1'b1;
        fetch_addr  = addr;
        forever begin
            @(negedge clk);
            k++;
            if (fetch_done) break;
            if (k > 60) break;
            @(posedge clk); #1;
        end
        last_k   = k;
        last_rsp = rsp_total;
        last_req = req_total;
        chk(fetch_done, {req, " completes"}, 32'(fetch_done), 32'd1);
        chk(fetch_word == mem_word(addr), {req, " word"}, fetch_word, mem_word(addr));
        if (lat_chk)
            chk(k == (mh ? 1 : LAT + 2), {req, (mh ? " R2 hit latency" : " R5 miss latency")},
                32'(k), 32'(mh ? 1 : LAT + 2));
        vm[idx] = 1'b1;
        tm[idx] = tg;
        @(posedge clk); #1;
        fetch_valid = 1'b0;
    endtask

    task automatic do_inval(input logic [AW-1:0] addr);
        inval_valid = 1'b1;
        inval_addr  = addr;
        vm[int'(addr[6:5])] = 1'b0;
        @(posedge clk); #1;
        inval_valid = 1'b0;
    endtask

    task automatic quiesce();
        forever begin
            @(negedge clk);
            if (!mem_req && req_total == rsp_total && req_pos == 3'd0) break;
        end
        @(posedge clk); #1;
    endtask

    function automatic logic [AW-1:0] mk(input int tg, input int idx, input int w);
        return {9'(tg), 2'(idx), 3'(w), 2'b00};
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NL; i++) begin vm[i] = 1'b0; tm[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!fetch_done && !mem_req, "R10 reset outputs", {30'd0, fetch_done, mem_req}, 32'd0);
        @(posedge clk); #1;

        // R10 first fetch after reset misses, R5 critical word latency
        do_fetch(mk(0, 0, 3), 1'b1, "R10 R5 cold miss");
        quiesce();
        // R2 hit; R1 bits [1:0] ignored
        do_fetch(mk(0, 0, 3) | 16'h2, 1'b1, "R2 R1 hit");
        do_fetch(mk(0, 0, 7), 1'b1, "R2 hit other word");

        // R6 fetches to the line under refill
        quiesce();
        do_fetch(mk(3, 1, 5), 1'b1, "R5 miss");
        do_fetch(mk(3, 1, 6), 1'b0, "R6 next beat");
        chk(last_rsp % 8 != 0, "R6 served mid-refill", 32'(last_rsp), 32'd1);
        do_fetch(mk(3, 1, 4), 1'b0, "R6 last beat");
        chk(last_rsp % 8 != 0, "R6 wrap word mid-refill", 32'(last_rsp), 32'd7);

        // R7 other line waits for refill end
        quiesce();
        do_fetch(mk(1, 2, 0), 1'b1, "R5 miss line2");
        do_fetch(mk(0, 0, 3), 1'b0, "R7 other line");
        chk(last_rsp % 8 == 0 && last_req == last_rsp, "R7 waited for refill",
            32'(last_rsp), 32'(last_req));

        // R8 invalidate
        quiesce();
        do_inval(mk(0, 0, 1));
        do_fetch(mk(0, 0, 3), 1'b1, "R8 after invalidate");

        // R9 invalidate during own refill
        quiesce();
        do_fetch(mk(5, 3, 2), 1'b1, "R5 miss line3");
        do_inval(mk(5, 3, 0));
        quiesce();
        do_fetch(mk(5, 3, 2), 1'b1, "R9 killed line");

        // R11 conflict eviction, R1 index field
        quiesce();
        do_fetch(mk(2, 0, 4), 1'b1, "R11 new tag");
        quiesce();
        do_fetch(mk(0, 0, 3), 1'b1, "R11 old tag evicted");
        quiesce();
        do_fetch(mk(2, 1, 4), 1'b1, "R1 distinct index");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op = int'($urandom % 10);
            logic [AW-1:0] a = mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % 8));
            if (op == 0) begin
                do_inval(a);
            end else if (op < 4) begin
                quiesce();
                do_fetch(a, 1'b1, "R2 R5 R8 random timed");
            end else begin
                do_fetch(a, 1'b0, "R6 R7 R11 random");
            end
        end
        quiesce();
        report();
    end
endmodule